// File: doc/BRIEF.md
# Multiplexed Bus Cycle Controller

This block runs one processor-side transfer at a time on a bus whose low sixteen lines carry the address first and data afterwards. The top four lines carry the high address bits first and status afterwards. A request names a 20-bit address and 16-bit write data. It also carries the byte enables, a memory or I/O choice, a read or write choice, a two-bit segment code and the interrupt-enable flag. The controller then walks through four clock states, T1 to T4. It can insert wait states between T3 and T4.

In T1 the controller puts the address out and raises the address strobe. External logic latches the address on the strobe's falling edge. The upper-byte enable is also valid in T1. From T2 onward the low lines carry write data, or they are released so a device can drive read data. The top lines then show the status bits. The read, write and data-enable strobes are active from T2 through the last wait state. The memory/I-O and direction outputs stay valid for the whole transfer. The device holds off completion by keeping `ready` low. Read data is captured on the edge that ends the transfer phase and is returned with a one-cycle `done` pulse in T4.

Top module: `mux_bus_cycle`

## Requirements
- R1: Out of reset, and whenever no transfer is running: `ale`=0, `rd_n`=`wr_n`=`den_n`=1, `ad_oe`=0, `m_io`=1, `dt_r`=1, `busy`=0 and `done`=0.
- R2: `req_valid` high at a rising edge while `busy` is low starts a transfer, and the next cycle is T1. `busy` stays high from T1 through T4. A request held during T1..T4 is ignored, and `busy` is low in the cycle after T4.
- R3: In T1 and only in T1: `ale`=1, `ad_oe`=1, `ad_out` equals address bits 15..0, `hi_out` equals address bits 19..16, and `bhe_n` is the inverse of byte enable bit 1 (bit 1 = upper byte).
- R4: From T2 through T4, `hi_out` is {S6,S5,S4,S3} = {0, interrupt-enable, segment[1], segment[0]}, with segment 00 extra, 01 stack, 10 code, 11 data. `bhe_n` (status S7) is 1.
- R5: From T1 through T4, `m_io` is 1 for memory and 0 for I/O, and `dt_r` is 1 for a write and 0 for a read.
- R6: In a write, `ad_oe`=1 and `ad_out` equals the write data from T2 through T4. `wr_n` is low in T2, T3 and every wait state, and `rd_n` stays high.
- R7: In a read, `ad_oe`=0 from T2 through T4. `rd_n` is low in T2, T3 and every wait state, and `wr_n` stays high.
- R8: `den_n` is low in T2, T3 and every wait state for both directions, and high in T1 and T4.
- R9: `ready` is sampled on the edge ending T3 and on the edge ending each wait state. Low there adds one wait state, so a transfer with N low samples lasts 4+N cycles.
- R10: For a read, `ad_in` is captured on the edge where `ready` is sampled high. `rdata` shows the captured value while `done` is high, which is for exactly one cycle (T4). `rdata` holds that value afterwards. `done` also pulses in T4 of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Start a transfer (taken only when not busy) |
| req_addr | input | 20 | Transfer address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 1 upper byte |
| req_mem | input | 1 | 1 memory, 0 I/O |
| req_write | input | 1 | 1 write, 0 read |
| req_seg | input | 2 | Segment code shown in status |
| req_ie | input | 1 | Interrupt-enable flag shown in status |
| ready | input | 1 | Device ready; low inserts wait states |
| ad_in | input | 16 | Data read from the low bus lines |
| ad_out | output | 16 | Low bus lines: address, then write data |
| ad_oe | output | 1 | Drive enable for the low bus lines |
| hi_out | output | 4 | Top bus lines: high address, then status |
| ale | output | 1 | Address strobe |
| bhe_n | output | 1 | Upper-byte enable (T1), status S7 afterwards |
| m_io | output | 1 | Memory (1) or I/O (0) |
| dt_r | output | 1 | Transmit (1) or receive (0) |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| den_n | output | 1 | Transceiver data enable, active low |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Captured read data |

## Verification
Every output is decoded from the state register, so a wrong state shows up at the ports in the same cycle. The strobes, the drive enable or the address strobe take the wrong level, and the error is visible at the next sample point. A mistake in wait-state counting moves the `done` pulse and the rise of the strobes by whole cycles. The bench catches this by checking every cycle of each transfer. A wrong capture edge shows up as a stale or changed `rdata` at T4, because the bench changes `ad_in` after the capture edge.

// File: rtl/mux_bus_cycle.sv
module mux_bus_cycle #(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [1:0]    req_be,
  input  logic          req_mem,
  input  logic          req_write,
  input  logic [1:0]    req_seg,
  input  logic          req_ie,
  input  logic          ready,
  input  logic [DW-1:0] ad_in,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  output logic [AW-DW-1:0] hi_out,
  output logic          ale,
  output logic          bhe_n,
  output logic          m_io,
  output logic          dt_r,
  output logic          rd_n,
  output logic          wr_n,
  output logic          den_n,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rdata
);
  localparam int HW = AW - DW;

  typedef enum logic [2:0] {S_IDLE, S_T1, S_T2, S_T3, S_TW, S_T4} st_t;

  st_t st;
  logic [AW-1:0] r_addr;
  logic [DW-1:0] r_wdata;
  logic          r_bhe, r_mem, r_wr, r_ie;
  logic [1:0]    r_seg;

  logic active, xfer, sample;
  assign active = (st != S_IDLE);
  assign xfer   = (st == S_T2) || (st == S_T3) || (st == S_TW);
  assign sample = (st == S_T3) || (st == S_TW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      r_addr  <= '0;
      r_wdata <= '0;
      r_bhe   <= 1'b0;
      r_mem   <= 1'b0;
      r_wr    <= 1'b0;
      r_ie    <= 1'b0;
      r_seg   <= '0;
      rdata   <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          st      <= S_T1;
          r_addr  <= req_addr;
          r_wdata <= req_wdata;
          r_bhe   <= req_be[1];
          r_mem   <= req_mem;
          r_wr    <= req_write;
          r_ie    <= req_ie;
          r_seg   <= req_seg;
        end
        S_T1:   st <= S_T2;
        S_T2:   st <= S_T3;
        S_T3,
        S_TW:   st <= ready ? S_T4 : S_TW;
        default: st <= S_IDLE;
      endcase
      if (sample && ready && !r_wr) rdata <= ad_in;
    end
  end

  logic [HW-1:0] status;
  assign status = HW'({1'b0, r_ie, r_seg});

  assign ale    = (st == S_T1);
  assign ad_out = ale ? r_addr[DW-1:0] : r_wdata;
  assign ad_oe  = ale || (active && r_wr);
  assign hi_out = ale ? r_addr[AW-1:DW] : (active ? status : '0);
  assign bhe_n  = ale ? ~r_bhe : 1'b1;
  assign m_io   = active ? r_mem : 1'b1;
  assign dt_r   = active ? r_wr  : 1'b1;
  assign rd_n   = ~(xfer && !r_wr);
  assign wr_n   = ~(xfer && r_wr);
  assign den_n  = ~xfer;
  assign busy   = active;
  assign done   = (st == S_T4);

  assert_ale_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale && busy);
  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid) |=> ale);
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);
  assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));
  assert_write_dir_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> dt_r && ad_oe);
  assert_s6_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ale) |-> !hi_out[HW-1]);
  assert_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!den_n && !ready && !$rose(!den_n) && $past(!den_n)) |=> !den_n);
  assert_ale_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> den_n && rd_n && wr_n);
endmodule

// File: tb/mux_bus_cycle_test.sv
module mux_bus_cycle_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0] req_be = '0;
  logic req_mem = 1'b0, req_write = 1'b0, req_ie = 1'b0;
  logic [1:0] req_seg = '0;
  logic ready = 1'b1;
  logic [15:0] ad_in = '0;
  logic [15:0] ad_out, rdata;
  logic [3:0] hi_out;
  logic ad_oe, ale, bhe_n, m_io, dt_r, rd_n, wr_n, den_n, busy, done;

  int errors = 0;
  int total = 0;
  int cyc = 0;
  int unsigned seed = 32'h5eed1234;

  always #5 clk = ~clk;

  mux_bus_cycle uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .req_mem(req_mem),
    .req_write(req_write), .req_seg(req_seg), .req_ie(req_ie),
    .ready(ready), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
    .hi_out(hi_out), .ale(ale), .bhe_n(bhe_n), .m_io(m_io), .dt_r(dt_r),
    .rd_n(rd_n), .wr_n(wr_n), .den_n(den_n), .busy(busy), .done(done),
    .rdata(rdata));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_status(input logic [1:0] seg, input logic ie);
    return {1'b0, ie, seg};
  endfunction

  task automatic chk_idle(input string when);
    chk(ale == 0 && rd_n && wr_n && den_n && !ad_oe && !busy && !done,
        {"R1 idle strobes ", when}, {ale, rd_n, wr_n, den_n, ad_oe, busy, done}, 7'b0111000);
    chk(m_io && dt_r, {"R1 idle m_io/dt_r ", when}, {m_io, dt_r}, 2'b11);
  endtask

  task automatic run_cycle(input logic [19:0] a, input logic [15:0] wd, input logic [1:0] be,
                           input logic mem, input logic wr, input logic [1:0] seg,
                           input logic ie, input int waits, input logic [15:0] rv, input bit poke);
    logic [3:0] st;
    st = exp_status(seg, ie);
    @(negedge clk);
    chk(!busy, "R2 not busy before start", busy, 0);
    req_addr = a; req_wdata = wd; req_be = be; req_mem = mem;
    req_write = wr; req_seg = seg; req_ie = ie; req_valid = 1'b1;
    @(negedge clk); // T1
    req_valid = poke;
    if (poke) begin req_addr = ~a; req_wdata = ~wd; req_write = ~wr; end
    chk(ale && ad_oe, "R3 T1 ale/oe", {ale, ad_oe}, 2'b11);
    chk(ad_out == a[15:0], "R3 T1 low address", ad_out, a[15:0]);
    chk(hi_out == a[19:16], "R3 T1 high address", hi_out, a[19:16]);
    chk(bhe_n == ~be[1], "R3 T1 bhe_n", bhe_n, ~be[1]);
    chk(m_io == mem && dt_r == wr, "R5 T1 m_io/dt_r", {m_io, dt_r}, {mem, wr});
    chk(den_n && rd_n && wr_n, "R8 T1 strobes high", {den_n, rd_n, wr_n}, 3'b111);
    chk(busy, "R2 busy in T1", busy, 1);
    @(negedge clk); // T2
    chk(!ale, "R3 ale low in T2", ale, 0);
    chk(hi_out == st, "R4 T2 status", hi_out, st);
    chk(bhe_n, "R4 T2 S7", bhe_n, 1);
    chk(rd_n == wr && wr_n == !wr, wr ? "R6 T2 write strobe" : "R7 T2 read strobe",
        {rd_n, wr_n}, {wr, !wr});
    chk(!den_n, "R8 T2 den_n low", den_n, 0);
    chk(ad_oe == wr, wr ? "R6 T2 drive" : "R7 T2 release", ad_oe, wr);
    if (wr) chk(ad_out == wd, "R6 T2 write data", ad_out, wd);
    @(negedge clk); // T3
    ad_in = rv;
    ready = (waits == 0);
    chk(!den_n && rd_n == wr && wr_n == !wr, "R9 T3 strobes", {den_n, rd_n, wr_n}, {1'b0, wr, !wr});
    chk(m_io == mem && dt_r == wr, "R5 T3 m_io/dt_r", {m_io, dt_r}, {mem, wr});
    for (int w = 0; w < waits; w++) begin
      @(negedge clk); // wait state
      chk(!done && busy, "R9 wait no done", {done, busy}, 2'b01);
      chk(!den_n && rd_n == wr && wr_n == !wr, "R9 wait strobes", {den_n, rd_n, wr_n}, {1'b0, wr, !wr});
      chk(hi_out == st, "R4 wait status", hi_out, st);
      ready = (w == waits - 1);
    end
    @(negedge clk); // T4
    ad_in = ~rv;
    chk(done, "R10 done in T4", done, 1);
    if (!wr) chk(rdata == rv, "R10 read data", rdata, rv);
    else chk(ad_oe && ad_out == wd, "R6 T4 write data", ad_out, wd);
    if (!wr) chk(!ad_oe, "R7 T4 released", ad_oe, 0);
    chk(den_n && rd_n && wr_n, "R8 T4 strobes high", {den_n, rd_n, wr_n}, 3'b111);
    chk(m_io == mem && dt_r == wr, "R5 T4 m_io/dt_r", {m_io, dt_r}, {mem, wr});
    chk(hi_out == st && bhe_n, "R4 T4 status", {hi_out, bhe_n}, {st, 1'b1});
    req_valid = 1'b0;
    ready = 1'b1;
    @(negedge clk); // idle
    chk_idle(poke ? "R2 after ignored request" : "after cycle");
    if (!wr) chk(rdata == rv, "R10 rdata held", rdata, rv);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      errors++; total++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, 100000);
      $display("Result: errors=%0d of %0d checks", errors, total);
      $finish;
    end
  end

  initial begin
    void'($urandom(seed));
    #23;
    @(negedge clk);
    chk_idle("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R1 after reset");
    req_valid = 1'b0;
    // directed cases
    run_cycle(20'hABCDE, 16'h1234, 2'b10, 1, 1, 2'b00, 1, 0, 16'h0, 0);
    run_cycle(20'h5A5A5, 16'h0, 2'b01, 0, 0, 2'b01, 0, 0, 16'hBEEF, 0);
    run_cycle(20'hF0F0F, 16'h0, 2'b11, 1, 0, 2'b10, 1, 3, 16'hC0DE, 0);
    run_cycle(20'h12345, 16'h9876, 2'b00, 0, 1, 2'b11, 0, 2, 16'h0, 0);
    run_cycle(20'h0FFFF, 16'h4321, 2'b10, 1, 0, 2'b11, 1, 1, 16'h7E57, 1);
    // random
    for (int i = 0; i < 60; i++) begin
      run_cycle($urandom(), $urandom(), $urandom(), $urandom(), $urandom(),
                $urandom(), $urandom(), $urandom_range(0, 4), $urandom(), ($urandom() % 4) == 0);
    end
    $display("Result: errors=%0d of %0d checks", errors, total);
    $finish;
  end
endmodule